// File: doc/BRIEF.md
# Wake-On-Receive Duty Cycle Timer

This block turns a slow 4 kHz tick, delivered as a one-clock strobe in the system clock domain, into a repeating schedule of listen and rest. While the cyclic receive enable is high it keeps `rx_window` high for a short active phase, then low for a much longer sleep phase, and repeats this pattern indefinitely. The active phase lasts one more tick than a 6-bit length field. The sleep phase lasts one more than a 10-bit field, multiplied by 32 ticks. This gives roughly 250 µs to 16 ms of listening and 8 ms to 8.192 s of rest.

The two lengths come from two 8-bit configuration words. The low word carries the lower eight bits of the sleep field. The high word carries the active field in its low six bits and the top two sleep bits in its upper two bits.

A second, independent timer drives a periodic wake pulse for a host processor. Its period equals either the active length or the sleep length, chosen by a select input. It runs only while both its own enable and the oscillator enable are high. Length changes are picked up only at the next phase or period boundary, so a phase in progress always completes with the length it started with.

Top module: `wor_duty_timer`

## Requirements
- R1: While cyclic receive is enabled, each active phase keeps `rx_window` high for exactly ACT+1 ticks, where ACT = `cfg_hi[5:0]`. The phase ends at the clock edge that samples its (ACT+1)-th tick.
- R2: Each sleep phase keeps `rx_window` low for exactly (SLP+1)×32 ticks, after which a new active phase begins.
- R3: SLP is the 10-bit value {`cfg_hi[7:6]`, `cfg_lo[7:0]`}, with `cfg_hi[7]` as its most significant bit.
- R4: When `wor_en` is first sampled high, `rx_window` rises at that same clock edge and the schedule starts with an active phase. A tick present in that sampling cycle is not counted.
- R5: When `wor_en` is sampled low, `rx_window` is low after that edge and all phase counting restarts from zero. A later enable begins a full active phase.
- R6: A change of ACT, SLP or `wake_sel` never alters a phase or wake period already in progress. It takes effect from the next boundary.
- R7: `wake_out` stays low, and its timer stays cleared, unless both `wake_en` and `osc_en` are sampled high.
- R8: With `wake_sel` = 0 the wake period is ACT+1 ticks; with `wake_sel` = 1 it is (SLP+1)×32 ticks. The first period starts at the edge where both enables are first sampled high.
- R9: `wake_out` rises at the edge that samples the tick ending a wake period and falls at the edge that samples the next tick. A period of one tick therefore holds it high.
- R10: During and directly after reset, `rx_window` and `wake_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | One-cycle strobe at the 4 kHz rate |
| wor_en | input | 1 | Cyclic receive enable |
| wake_en | input | 1 | Periodic wake output enable |
| osc_en | input | 1 | Low-frequency oscillator enable, gates the wake output |
| wake_sel | input | 1 | Wake period source: 0 active length, 1 sleep length |
| cfg_lo | input | 8 | Sleep field bits 7..0 |
| cfg_hi | input | 8 | [5:0] active field, [7:6] sleep field bits 9..8 |
| rx_window | output | 1 | High during the active (receive) phase |
| wake_out | output | 1 | Periodic wake pulse, one tick wide |

## Verification
A wrong tick count or phase register shows at the port as an `rx_window` edge that is one or more ticks early or late. This is visible at the first phase boundary after the fault. A length latched at the wrong time, or split incorrectly across the two words, only appears at the end of the affected phase, so the stimulus changes lengths in mid-phase. It also uses a sleep field with a non-zero upper part. Errors in the wake timer appear within one period of the selected length, as a misplaced or missing `wake_out` edge. Errors in its gating appear at the first tick after either enable changes.

// File: rtl/wor_timer_pkg.sv
package wor_timer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_SLEEP  = 2'd2
  } wor_phase_t;
endpackage

// File: rtl/wor_len_decode.sv
module wor_len_decode #(
  parameter int REG_W    = 8,
  parameter int ACT_W    = 6,
  parameter int SLP_W    = 10,
  parameter int PRE_LOG2 = 5,
  localparam int CNT_W    = SLP_W + PRE_LOG2,
  localparam int SLP_HI_W = SLP_W - REG_W
) (
  input  logic [REG_W-1:0] cfg_lo,
  input  logic [REG_W-1:0] cfg_hi,
  output logic [CNT_W-1:0] act_term,
  output logic [CNT_W-1:0] slp_term
);
  // terminal count = length - 1; the prescale appears as trailing ones
  assign act_term = {{(CNT_W-ACT_W){1'b0}}, cfg_hi[ACT_W-1:0]};
  assign slp_term = {cfg_hi[REG_W-1 -: SLP_HI_W], cfg_lo, {PRE_LOG2{1'b1}}};
endmodule

// File: rtl/wor_period_counter.sv
module wor_period_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] term_in,
  output logic             done
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_q, term_d;
  logic             ce;

  assign done = run & run_q & tick & (cnt_q == term_q);
  assign ce   = tick | (run ^ run_q);

  always_comb begin
    run_d  = run;
    cnt_d  = cnt_q;
    term_d = term_q;
    if (!run) begin
      cnt_d  = '0;
      term_d = '0;
    end else if (!run_q || done) begin
      cnt_d  = '0;
      term_d = term_in;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      term_q <= '0;
    end else if (ce) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      term_q <= term_d;
    end
  end
endmodule

// File: rtl/wor_cycle_ctrl.sv
module wor_cycle_ctrl
  import wor_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wor_en,
  input  logic       period_done,
  output wor_phase_t phase
);
  wor_phase_t phase_d;

  always_comb begin
    phase_d = phase;
    if (!wor_en) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:   phase_d = PH_ACTIVE;
        PH_ACTIVE: if (period_done) phase_d = PH_SLEEP;
        PH_SLEEP:  if (period_done) phase_d = PH_ACTIVE;
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/wor_duty_timer.sv
module wor_duty_timer
  import wor_timer_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int ACT_W    = 6,
  parameter int SLP_W    = 10,
  parameter int PRE_LOG2 = 5,
  localparam int CNT_W   = SLP_W + PRE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_tick,
  input  logic             wor_en,
  input  logic             wake_en,
  input  logic             osc_en,
  input  logic             wake_sel,
  input  logic [REG_W-1:0] cfg_lo,
  input  logic [REG_W-1:0] cfg_hi,
  output logic             rx_window,
  output logic             wake_out
);
  logic [CNT_W-1:0] act_term, slp_term;
  logic [CNT_W-1:0] wor_term, wake_term;
  logic             wor_done, wake_done, wake_run;
  logic             wake_q, wake_d;
  wor_phase_t       phase;

  wor_len_decode #(.REG_W(REG_W), .ACT_W(ACT_W), .SLP_W(SLP_W), .PRE_LOG2(PRE_LOG2)) u_dec (
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .act_term(act_term), .slp_term(slp_term));

  // length loaded for the phase about to start
  assign wor_term = (phase == PH_ACTIVE) ? slp_term : act_term;

  wor_period_counter #(.CNT_W(CNT_W)) u_wor_cnt (
    .clk(clk), .rst_n(rst_n), .run(wor_en), .tick(lf_tick),
    .term_in(wor_term), .done(wor_done));

  wor_cycle_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wor_en(wor_en), .period_done(wor_done), .phase(phase));

  assign rx_window = (phase == PH_ACTIVE);

  assign wake_run  = wake_en & osc_en;
  assign wake_term = wake_sel ? slp_term : act_term;

  wor_period_counter #(.CNT_W(CNT_W)) u_wake_cnt (
    .clk(clk), .rst_n(rst_n), .run(wake_run), .tick(lf_tick),
    .term_in(wake_term), .done(wake_done));

  always_comb begin
    wake_d = wake_q;
    if (!wake_run)      wake_d = 1'b0;
    else if (wake_done) wake_d = 1'b1;
    else if (lf_tick)   wake_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_out = wake_q;
endmodule

// File: rtl/wor_duty_timer_chk.sv
module wor_duty_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic lf_tick,
  input logic wor_en,
  input logic wake_en,
  input logic osc_en,
  input logic rx_window,
  input logic wake_out
);
  p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wor_en |=> !rx_window);

  p_start_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wor_en) |=> rx_window);

  p_active_end_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_window) |-> ($past(lf_tick) || !$past(wor_en)));

  p_wake_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_en && osc_en) |=> !wake_out);

  p_wake_moves_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wake_out) |-> ($past(lf_tick) || !$past(wake_en && osc_en)));

  p_wake_rise_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_out) |-> $past(wake_en && osc_en));
endmodule

bind wor_duty_timer wor_duty_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .wor_en(wor_en),
  .wake_en(wake_en), .osc_en(osc_en), .rx_window(rx_window), .wake_out(wake_out));

// File: tb/wor_duty_timer_bench.sv
module wor_duty_timer_bench;
  logic clk, rst_n, lf_tick, wor_en, wake_en, osc_en, wake_sel;
  logic [7:0] cfg_lo, cfg_hi;
  logic rx_window, wake_out;

  int total, fails;
  string rx_tag, wk_tag;
  bit finished;

  // behavioural reference state
  int m_ph, m_cnt, m_len;
  int m_wrun, m_wcnt, m_wlen, m_wake;
  int act_len, slp_len;
  int tdiv;

  wor_duty_timer u_wor_duty_timer (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .wor_en(wor_en),
    .wake_en(wake_en), .osc_en(osc_en), .wake_sel(wake_sel),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .rx_window(rx_window), .wake_out(wake_out));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // tick generator: one strobe every 3 clocks, driven away from the active edge
  initial begin
    tdiv = 0;
    lf_tick = 1'b0;
  end
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    lf_tick <= (tdiv == 0);
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: counts ticks of each phase in plain integers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_len = 0;
      m_wrun = 0; m_wcnt = 0; m_wlen = 0; m_wake = 0;
    end else begin
      act_len = int'(cfg_hi[5:0]) + 1;
      slp_len = (int'({cfg_hi[7:6], cfg_lo}) + 1) * 32;
      if (!wor_en) begin
        m_ph = 0; m_cnt = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0; m_len = act_len;
      end else if (lf_tick) begin
        m_cnt++;
        if (m_cnt == m_len) begin
          m_cnt = 0;
          if (m_ph == 1) begin m_ph = 2; m_len = slp_len; end
          else           begin m_ph = 1; m_len = act_len; end
        end
      end
      if (!(wake_en && osc_en)) begin
        m_wrun = 0; m_wcnt = 0; m_wake = 0;
      end else if (m_wrun == 0) begin
        m_wrun = 1; m_wcnt = 0; m_wlen = wake_sel ? slp_len : act_len;
      end else if (lf_tick) begin
        m_wcnt++;
        if (m_wcnt == m_wlen) begin
          m_wake = 1; m_wcnt = 0; m_wlen = wake_sel ? slp_len : act_len;
        end else begin
          m_wake = 0;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(rx_tag, rx_window, m_ph == 1);
      check(wk_tag, wake_out, m_wake == 1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    total = 0; fails = 0; finished = 0;
    rx_tag = "R10"; wk_tag = "R10";
    rst_n = 1'b0; wor_en = 1'b0; wake_en = 1'b0; osc_en = 1'b0; wake_sel = 1'b0;
    cfg_lo = 8'h00; cfg_hi = 8'h00;
    cycles(5);
    check("R10 rx_window in reset", rx_window, 1'b0);
    check("R10 wake_out in reset", wake_out, 1'b0);
    rst_n = 1'b1;
    cycles(3);

    // R1/R2/R4: ACT=3, SLP=0 -> 4 ticks on, 32 ticks off
    rx_tag = "R1/R2/R4";
    cfg_hi = 8'h03; cfg_lo = 8'h00;
    wor_en = 1'b1;
    cycles(1);
    check("R4 rx_window rises on enable", rx_window, 1'b1);
    cycles(330);

    // R6: new active length applied only at the next boundary
    rx_tag = "R6";
    cfg_hi = 8'h07;
    cycles(250);
    cfg_hi = 8'h01;
    cycles(250);

    // R3: split sleep field, SLP = 0x102 = 258, ACT = 5
    rx_tag = "R3/R2";
    cfg_hi = 8'h45; cfg_lo = 8'h02;
    cycles(26000);

    // R5: disable stops at once, re-enable starts a full active phase
    rx_tag = "R5";
    wor_en = 1'b0;
    cycles(1);
    check("R5 rx_window low after disable", rx_window, 1'b0);
    cycles(20);
    cfg_hi = 8'h02; cfg_lo = 8'h00;
    wor_en = 1'b1;
    cycles(1);
    check("R5 rx_window high after re-enable", rx_window, 1'b1);
    cycles(60);
    wor_en = 1'b0;
    cycles(4);

    // R7: wake enable without oscillator enable gives nothing
    wk_tag = "R7";
    wake_en = 1'b1; osc_en = 1'b0; cfg_hi = 8'h02;
    cycles(60);
    check("R7 wake_out gated by osc_en", wake_out, 1'b0);

    // R8/R9: active-length period (3 ticks)
    wk_tag = "R8/R9";
    osc_en = 1'b1;
    cycles(120);
    // single-tick period holds the pulse high
    cfg_hi = 8'h00;
    cycles(60);
    // R6/R8: switch to sleep-length period mid-period, with receive cycling too
    wk_tag = "R6/R8";
    rx_tag = "R1/R2";
    wor_en = 1'b1;
    wake_sel = 1'b1; cfg_hi = 8'h00; cfg_lo = 8'h00;
    cycles(400);
    wk_tag = "R7";
    wake_en = 1'b0;
    cycles(1);
    check("R7 wake_out low after wake_en drop", wake_out, 1'b0);
    cycles(30);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule